// File: doc/BRIEF.md
# Winning-Nonce Result Queue

This block sits between the hash engines and the host command path. Each time an engine reports a nonce that meets the target, it presents the nonce and the tag of the job it came from on the push side. The queue stores a small number of these results. The host drains them one at a time with a read-result command, which is modelled here as a single-cycle pop strobe.

Every pop is answered one cycle later by a reply code and a data bus. The reply code tells the host whether an entry was returned or the queue was empty. Hashing must never stall, so a full queue takes every new result and discards its oldest entry. If the host does not poll while the engines are working, results are lost.

A status byte also carries a work-active flag. The host reads it to tell whether the engines still have work or the chip is idle.

Top module: `nonce_result_queue`

## Requirements
- R1: While `rst_n` is low at a clock edge, the queue is emptied, `result_count` becomes 0, `rsp_valid` becomes 0 and the work-active flag is cleared. Results pushed before the reset are not returned after it.
- R2: Entries leave in the order they were pushed. Each returned nonce comes with the job tag that was pushed with it.
- R3: The queue holds DEPTH entries (4 by default). DEPTH pushes into an empty queue are all returned.
- R4: A push into a full queue with no pop in the same cycle discards the oldest entry. The DEPTH most recent results are kept and `result_count` stays at DEPTH.
- R5: A pop on a non-empty queue gives `rsp_valid`=1 on the following cycle. It also gives `rsp_code`=8'h18 (read opcode 8'h08 with acknowledge bit 4 set), the head nonce on `rsp_nonce` and its tag on `rsp_job`.
- R6: A pop on an empty queue gives `rsp_valid`=1 on the following cycle, with `rsp_code`=8'h08 (acknowledge bit clear) and zero nonce and job. The queue is left unchanged.
- R7: A push and a pop in the same cycle on a non-empty queue leave `result_count` unchanged, and the pop returns the oldest entry. On an empty queue, that pop reports empty and the pushed entry is stored.
- R8: `status_byte` bit 1 is the work-active flag and all other bits are 0. `job_load` sets the flag and `job_finished` clears it. If both are high in the same cycle, the flag is set. The flag changes on the edge where the strobe is sampled.
- R9: `result_count` gives the number of stored entries after each edge. It never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Engine offers a result this cycle |
| push_nonce | input | NONCE_W | Winning nonce |
| push_job | input | JOB_W | Job tag of the result |
| job_load | input | 1 | Host has loaded a job |
| job_finished | input | 1 | Engines have exhausted their work |
| pop_req | input | 1 | Read-result command strobe |
| rsp_valid | output | 1 | Reply present (one cycle after pop_req) |
| rsp_code | output | 8 | 8'h18 when an entry is returned, 8'h08 when empty |
| rsp_job | output | JOB_W | Job tag of the returned entry |
| rsp_nonce | output | NONCE_W | Returned nonce |
| result_count | output | $clog2(DEPTH+1) | Stored entries |
| status_byte | output | 8 | Bit 1 is work-active |

## Verification
The push and the pop can land on the same edge. This is the delicate case when the queue is full, because the slot being read is also the slot being overwritten, and when it is empty, because the pop must report empty even though a result arrives. The stimulus fills the queue and then drives both strobes together in both states. Random traffic with a high push and pop density also provokes the same pairing many times. Each reply and each count is compared with a queue model kept in the bench, which applies the pop before the push.

// File: rtl/nrq_pkg.sv
package nrq_pkg;
   // read-result opcode and the acknowledge bit the host decodes
   localparam logic [7:0] RD_OPCODE  = 8'h08;
   localparam logic [7:0] ACK_MASK   = 8'h10;
   // position of the work-active flag inside the status byte
   localparam int         ACTIVE_BIT = 1;

   function automatic logic [7:0] reply_code(input logic hit);
      return hit ? (RD_OPCODE | ACK_MASK) : RD_OPCODE;
   endfunction
endpackage

// File: rtl/nrq_ptrs.sv
module nrq_ptrs #(
   parameter int DEPTH = 4,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop_req,
   output logic [IW-1:0] rd_idx,
   output logic [IW-1:0] wr_idx,
   output logic          wr_en,
   output logic [CW-1:0] count,
   output logic          nonempty
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("nrq_ptrs: DEPTH must be a power of two, at least 2");
   end

   logic full, do_pop, drop;

   assign nonempty = (count != '0);
   assign full     = (count == FULL_CNT);
   assign do_pop   = pop_req && nonempty;
   assign drop     = push && full && !do_pop;
   assign wr_en    = push;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx <= '0;
         wr_idx <= '0;
         count  <= '0;
      end else begin
         if (push)
            wr_idx <= wr_idx + 1'b1;
         if (do_pop || drop)
            rd_idx <= rd_idx + 1'b1;
         if (push && !do_pop && !full)
            count <= count + 1'b1;
         else if (do_pop && !push)
            count <= count - 1'b1;
      end
   end

   // R9
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);

   // R4
   full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop_req) |=> (count == FULL_CNT));

   // R7
   push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop_req && nonempty) |=> $stable(count));

   // R6
   empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !nonempty && !push) |=> (count == '0));
endmodule

// File: rtl/nrq_store.sv
module nrq_store #(
   parameter int DEPTH = 4,
   parameter int W     = 36,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [W-1:0]  wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [W-1:0]  rd_data
);
   if (W < 1) begin : g_bad_width
      $error("nrq_store: W must be positive");
   end

   logic [W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == IW'(g)))
            q <= wr_data;
      end
      assign slot_q[g] = q;
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/nrq_busy.sv
module nrq_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic job_load,
   input  logic job_finished,
   output logic active
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         active <= 1'b0;
      else if (job_load)
         active <= 1'b1;
      else if (job_finished)
         active <= 1'b0;
   end

   // R8
   load_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      job_load |=> active);

   // R8
   finish_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (job_finished && !job_load) |=> !active);
endmodule

// File: rtl/nonce_result_queue.sv
module nonce_result_queue #(
   parameter int DEPTH   = 4,
   parameter int NONCE_W = 32,
   parameter int JOB_W   = 4,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int EW = NONCE_W + JOB_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_valid,
   input  logic [NONCE_W-1:0] push_nonce,
   input  logic [JOB_W-1:0]   push_job,
   input  logic               job_load,
   input  logic               job_finished,
   input  logic               pop_req,
   output logic               rsp_valid,
   output logic [7:0]         rsp_code,
   output logic [JOB_W-1:0]   rsp_job,
   output logic [NONCE_W-1:0] rsp_nonce,
   output logic [CW-1:0]      result_count,
   output logic [7:0]         status_byte
);
   import nrq_pkg::*;

   if (NONCE_W < 1 || JOB_W < 1) begin : g_bad_fields
      $error("nonce_result_queue: field widths must be positive");
   end

   logic [IW-1:0] rd_idx, wr_idx;
   logic          wr_en, nonempty, active;
   logic [EW-1:0] head;

   nrq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push(push_valid), .pop_req(pop_req),
      .rd_idx(rd_idx), .wr_idx(wr_idx), .wr_en(wr_en),
      .count(result_count), .nonempty(nonempty)
   );

   nrq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data({push_job, push_nonce}), .rd_idx(rd_idx), .rd_data(head)
   );

   nrq_busy u_busy (
      .clk(clk), .rst_n(rst_n), .job_load(job_load),
      .job_finished(job_finished), .active(active)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_code  <= '0;
         rsp_job   <= '0;
         rsp_nonce <= '0;
      end else begin
         rsp_valid <= pop_req;
         if (pop_req) begin
            rsp_code  <= reply_code(nonempty);
            rsp_job   <= nonempty ? head[EW-1:NONCE_W] : '0;
            rsp_nonce <= nonempty ? head[NONCE_W-1:0] : '0;
         end
      end
   end

   always_comb begin
      status_byte             = '0;
      status_byte[ACTIVE_BIT] = active;
   end

   // R5
   hit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && result_count != '0) |=> (rsp_valid && rsp_code == 8'h18));

   // R6
   empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && result_count == '0) |=> (rsp_valid && rsp_code == 8'h08 && rsp_nonce == '0));

   // R5
   idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pop_req |=> !rsp_valid);
endmodule

// File: tb/nonce_result_queue_tb.sv
module nonce_result_queue_tb;
   localparam int DEPTH = 4;
   localparam int NW = 32;
   localparam int JW = 4;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_valid = 1'b0, job_load = 1'b0, job_finished = 1'b0, pop_req = 1'b0;
   logic [NW-1:0] push_nonce = '0;
   logic [JW-1:0] push_job = '0;
   logic rsp_valid;
   logic [7:0] rsp_code, status_byte;
   logic [JW-1:0] rsp_job;
   logic [NW-1:0] rsp_nonce;
   logic [CW-1:0] result_count;

   int checks = 0;
   int errors = 0;
   logic [NW+JW-1:0] mq[$];

   always #2.5 clk = ~clk;

   nonce_result_queue #(.DEPTH(DEPTH), .NONCE_W(NW), .JOB_W(JW)) u_dut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_nonce(push_nonce),
      .push_job(push_job), .job_load(job_load), .job_finished(job_finished),
      .pop_req(pop_req), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .rsp_job(rsp_job), .rsp_nonce(rsp_nonce), .result_count(result_count),
      .status_byte(status_byte)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic logic [7:0] exp_code(input bit hit);
      return hit ? 8'h18 : 8'h08;
   endfunction

   // one cycle: drive at negedge, compare at the following negedge
   task automatic step(input string tag, input bit p, input logic [NW-1:0] n,
                       input logic [JW-1:0] j, input bit q);
      bit hit;
      logic [NW+JW-1:0] hd;
      push_valid = p; push_nonce = n; push_job = j; pop_req = q;
      hit = (mq.size() > 0);
      hd = hit ? mq[0] : '0;
      if (q && hit) void'(mq.pop_front());
      if (p) begin
         if (mq.size() == DEPTH) void'(mq.pop_front());
         mq.push_back({j, n});
      end
      @(posedge clk); @(negedge clk);
      push_valid = 1'b0; pop_req = 1'b0;
      check({tag, " rsp_valid"}, 64'(rsp_valid), 64'(q));
      if (q) begin
         check({tag, " rsp_code"}, 64'(rsp_code), 64'(exp_code(hit)));
         check({tag, " rsp_job"}, 64'(rsp_job), 64'(hd[NW+JW-1:NW]));
         check({tag, " rsp_nonce"}, 64'(rsp_nonce), 64'(hd[NW-1:0]));
      end
      check({tag, " count"}, 64'(result_count), 64'(mq.size()));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      mq.delete();
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      do_reset();
      // R1 reset state
      check("R1 count", 64'(result_count), 0);
      check("R1 rsp_valid", 64'(rsp_valid), 0);
      check("R1 status", 64'(status_byte), 0);

      // R6 empty read leaves state alone
      step("R6 empty", 0, '0, '0, 1);

      // R3 / R2 fill to capacity and drain in order
      for (int i = 0; i < DEPTH; i++) step("R3 fill", 1, 32'hA000_0000 + i, JW'(i + 1), 0);
      for (int i = 0; i < DEPTH; i++) step("R2 drain", 0, '0, '0, 1);
      step("R6 after drain", 0, '0, '0, 1);

      // R4 overflow drops oldest
      for (int i = 0; i < DEPTH + 2; i++) step("R4 over", 1, 32'hB000_0000 + i, JW'(i), 0);
      check("R4 count sat", 64'(result_count), DEPTH);
      step("R5 head after overflow", 0, '0, '0, 1);

      // R7 push+pop on full queue, then on empty queue
      step("R7 full both", 1, 32'hC0DE_0001, 4'h9, 1);
      while (mq.size() > 0) step("R2 drain2", 0, '0, '0, 1);
      step("R7 empty both", 1, 32'hC0DE_0002, 4'h3, 1);
      step("R5 single", 0, '0, '0, 1);

      // R8 work flag
      job_load = 1; @(posedge clk); @(negedge clk); job_load = 0;
      check("R8 load", 64'(status_byte), 8'h02);
      job_finished = 1; @(posedge clk); @(negedge clk); job_finished = 0;
      check("R8 finish", 64'(status_byte), 8'h00);
      job_load = 1; job_finished = 1; @(posedge clk); @(negedge clk);
      job_load = 0; job_finished = 0;
      check("R8 both", 64'(status_byte), 8'h02);

      // R1 reset mid-run flushes stored results and the flag
      step("R9 pre", 1, 32'h1111_2222, 4'h5, 0);
      do_reset();
      check("R1 flush count", 64'(result_count), 0);
      check("R1 flush status", 64'(status_byte), 0);
      step("R1 flush read", 0, '0, '0, 1);

      // R2 R4 R7 R9 random traffic
      for (int k = 0; k < 600; k++) begin
         bit p, q;
         p = ($urandom % 100) < 60;
         q = ($urandom % 100) < 45;
         step("R9 random", p, NW'($urandom), JW'($urandom), q);
      end
      summary();
   end
endmodule